// File: doc/BRIEF.md
# Mid-Bit Sampling Serial Receiver

This block turns an asynchronous serial line into parallel characters. It passes the raw line through a two-flop synchronizer and waits in idle for a high-to-low transition of the synchronized line. That transition restarts an oversampling counter, so every later sample falls near the centre of a bit cell. The block then checks that the line is still low halfway through the start bit. A high level at that point is treated as a glitch, and the machine goes back to idle. Otherwise it reads each data bit at its centre, least significant bit first, and tests the stop bit.

The default character is eight data bits with one stop bit and no parity. A build-time parameter adds a parity bit after the data, and a second parameter selects even or odd parity. The timing source is a tick from an external rate divider that pulses once per sixteenth of a bit (the oversampling factor is a parameter). When a character completes, the received word appears on the data output together with a one-cycle ready strobe. If the character is faulty, it appears with a one-cycle error strobe instead.

Top module: `uart_rx_mid`

## Requirements
- R1: The raw line is synchronized by two flops, and the idle state leaves only on a high-to-low transition of the synchronized line; a line held low produces no further character.
- R2: The transition that leaves idle clears the oversampling counter, and the start bit is sampled after OVS/2 ticks.
- R3: A start bit sampled high returns the machine to idle with no ready or error strobe, and the data output keeps its previous value.
- R4: Each data bit is sampled OVS ticks after the previous sample, and the first bit received lands in data bit 0 (least significant bit first).
- R5: A stop bit sampled high with no parity fault raises rx_ready for exactly one clock, and the new word is on rx_data in that same clock.
- R6: A stop bit sampled low raises rx_err for exactly one clock and no rx_ready, and the received word is still placed on rx_data.
- R7: rx_data changes only in a clock where rx_ready or rx_err is high, and otherwise holds the last word.
- R8: With PARITY_EN=1, one parity bit follows the data. With PARITY_ODD=0 it must equal the XOR of the data bits (even parity); with PARITY_ODD=1 it must equal the inverted XOR. A mismatch raises rx_err instead of rx_ready, and the word is still presented.
- R9: rx_ready and rx_err are never high in the same clock.
- R10: While rst is high and after its release, rx_ready and rx_err are low and rx_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_raw | input | 1 | Asynchronous serial line, idle high |
| tick16 | input | 1 | Oversampling tick, one pulse per 1/OVS bit |
| rx_data | output | DATA_BITS | Last received word |
| rx_ready | output | 1 | One-cycle strobe for a good character |
| rx_err | output | 1 | One-cycle strobe for a framing or parity fault |

## Verification
The bench builds two copies of the block, both with OVS=16 and a tick every second clock. The first copy uses the default frame. It receives every one of the 256 byte values, which reaches every bit position of the least-significant-first shift (R4). It also sees bad stop bits, short low glitches, and a long break that holds the line low. The second copy has PARITY_EN=1 with even parity. It receives a stepped sweep of bytes, each sent once with a correct parity bit and once with a wrong one.

// File: rtl/uart_rx_mid.sv
module uart_rx_mid #(
  parameter int DATA_BITS  = 8,
  parameter int OVS        = 16,
  parameter bit PARITY_EN  = 1'b0,
  parameter bit PARITY_ODD = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_raw,
  input  logic                 tick16,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_ready,
  output logic                 rx_err
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(DATA_BITS + 1);
  localparam int HALF = OVS / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t                  st;
  logic [2:0]           sh;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bitn;
  logic [DATA_BITS-1:0] shreg;
  logic                 par_acc, par_bad;

  wire rx_s     = sh[1];
  wire fall     = sh[2] & ~sh[1];
  wire at_half  = tick16 && (cnt == CW'(HALF - 1));
  wire at_full  = tick16 && (cnt == CW'(OVS - 1));
  wire last_bit = (bitn == BW'(DATA_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) sh <= 3'b111;
    else     sh <= {sh[1:0], rx_raw};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      par_acc  <= 1'b0;
      par_bad  <= 1'b0;
      rx_data  <= '0;
      rx_ready <= 1'b0;
      rx_err   <= 1'b0;
    end else begin
      rx_ready <= 1'b0;
      rx_err   <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt  <= '0;
          bitn <= '0;
          if (fall) st <= S_START;
        end
        S_START: begin
          if (at_half) begin
            cnt     <= '0;
            par_acc <= PARITY_ODD;
            par_bad <= 1'b0;
            st      <= rx_s ? S_IDLE : S_DATA;
          end else if (tick16) cnt <= cnt + 1'b1;
        end
        S_DATA: begin
          if (at_full) begin
            cnt     <= '0;
            shreg   <= {rx_s, shreg[DATA_BITS-1:1]};
            par_acc <= par_acc ^ rx_s;
            bitn    <= bitn + 1'b1;
            if (last_bit) st <= PARITY_EN ? S_PAR : S_STOP;
          end else if (tick16) cnt <= cnt + 1'b1;
        end
        S_PAR: begin
          if (at_full) begin
            cnt     <= '0;
            par_bad <= par_acc ^ rx_s;
            st      <= S_STOP;
          end else if (tick16) cnt <= cnt + 1'b1;
        end
        S_STOP: begin
          if (at_full) begin
            cnt     <= '0;
            rx_data <= shreg;
            if (rx_s && !par_bad) rx_ready <= 1'b1;
            else                  rx_err   <= 1'b1;
            st <= S_IDLE;
          end else if (tick16) cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_NEEDS_FALL: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !fall) |=> st == S_IDLE); // R1
  AST_EDGE_CLEARS_CNT: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && fall) |=> (st == S_START && cnt == '0)); // R2
  AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (rst)
    (st == S_START && at_half && rx_s) |=> (st == S_IDLE && !rx_ready && !rx_err)); // R3
  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_ready |=> !rx_ready); // R5
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_err |=> !rx_err); // R6
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_data) |-> (rx_ready || rx_err)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rx_ready && rx_err)); // R9
endmodule

// File: tb/tb_uart_rx_mid.sv
module tb_uart_rx_mid;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 2;
  localparam int OVS        = 16;
  localparam int BIT_CLKS   = OVS * TDIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_a = 1'b1, rx_b = 1'b1;
  logic tick16 = 1'b0;
  int   tdiv_cnt = 0;
  logic [7:0] data_a, data_b;
  logic rdy_a, err_a, rdy_b, err_b;

  int checks = 0, failures = 0;
  int nrdy_a = 0, nerr_a = 0, nrdy_b = 0, nerr_b = 0;
  logic prev_rdy_a = 0, prev_err_a = 0, prev_rdy_b = 0, prev_err_b = 0;
  logic [7:0] last_a = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tdiv_cnt <= (tdiv_cnt == TDIV-1) ? 0 : tdiv_cnt + 1;
    tick16   <= (tdiv_cnt == TDIV-1);
  end

  uart_rx_mid #(.DATA_BITS(8), .OVS(OVS), .PARITY_EN(1'b0), .PARITY_ODD(1'b0)) dut (
    .clk(clk), .rst(rst), .rx_raw(rx_a), .tick16(tick16),
    .rx_data(data_a), .rx_ready(rdy_a), .rx_err(err_a));

  uart_rx_mid #(.DATA_BITS(8), .OVS(OVS), .PARITY_EN(1'b1), .PARITY_ODD(1'b0)) dut_par (
    .clk(clk), .rst(rst), .rx_raw(rx_b), .tick16(tick16),
    .rx_data(data_b), .rx_ready(rdy_b), .rx_err(err_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitors: strobe counts, strobe width (R5, R6), exclusivity (R9), data hold (R7)
  always @(negedge clk) if (!rst) begin
    if (rdy_a) nrdy_a++;
    if (err_a) nerr_a++;
    if (rdy_b) nrdy_b++;
    if (err_b) nerr_b++;
    if (rdy_a && prev_rdy_a) chk(0, "R5 ready width", 2, 1);
    if (err_a && prev_err_a) chk(0, "R6 err width", 2, 1);
    if (rdy_b && prev_rdy_b) chk(0, "R5 ready width par", 2, 1);
    if (err_b && prev_err_b) chk(0, "R8 err width par", 2, 1);
    if ((rdy_a && err_a) || (rdy_b && err_b)) chk(0, "R9 both strobes", 1, 0);
    if (data_a != last_a && !rdy_a && !err_a) chk(0, "R7 data changed", data_a, last_a);
    last_a = data_a;
    prev_rdy_a = rdy_a; prev_err_a = err_a;
    prev_rdy_b = rdy_b; prev_err_b = err_b;
  end

  task automatic hold_a(input logic v, input int n);
    rx_a = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_b(input logic v, input int n);
    rx_b = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_a(input logic [7:0] d, input logic stop);
    hold_a(1'b0, BIT_CLKS);
    for (int i = 0; i < 8; i++) hold_a(d[i], BIT_CLKS);
    hold_a(stop, BIT_CLKS);
    hold_a(1'b1, BIT_CLKS);
  endtask

  task automatic frame_b(input logic [7:0] d, input logic p);
    hold_b(1'b0, BIT_CLKS);
    for (int i = 0; i < 8; i++) hold_b(d[i], BIT_CLKS);
    hold_b(p, BIT_CLKS);
    hold_b(1'b1, BIT_CLKS);
    hold_b(1'b1, BIT_CLKS);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r0, e0;
    logic [7:0] keep;
    repeat (5) @(negedge clk);
    chk(rdy_a == 0 && err_a == 0, "R10 strobes in reset", {rdy_a, err_a}, 0);
    chk(data_a == 0 && data_b == 0, "R10 data in reset", data_a, 0);
    rst = 1'b0;
    repeat (3 * BIT_CLKS) @(negedge clk);
    chk(nrdy_a == 0 && nerr_a == 0, "R10 idle after reset", nrdy_a + nerr_a, 0);
    chk(data_a == 0, "R10 data after reset", data_a, 0);

    // R4 R5: full byte sweep, LSB first
    for (int v = 0; v < 256; v++) begin
      r0 = nrdy_a; e0 = nerr_a;
      frame_a(8'(v), 1'b1);
      chk(nrdy_a == r0 + 1, "R5 ready count", nrdy_a - r0, 1);
      chk(nerr_a == e0, "R5 no err", nerr_a - e0, 0);
      chk(data_a == 8'(v), "R4 data value", data_a, v);
    end

    // R6: bad stop bit still presents the word
    for (int v = 0; v < 256; v += 37) begin
      r0 = nrdy_a; e0 = nerr_a;
      frame_a(8'(v ^ 8'h5A), 1'b0);
      hold_a(1'b1, BIT_CLKS);
      chk(nerr_a == e0 + 1, "R6 err count", nerr_a - e0, 1);
      chk(nrdy_a == r0, "R6 no ready", nrdy_a - r0, 0);
      chk(data_a == 8'(v ^ 8'h5A), "R6 data presented", data_a, v ^ 8'h5A);
    end

    // R3 R2 R7: glitches shorter than half a bit are rejected
    frame_a(8'hC3, 1'b1);
    keep = data_a;
    for (int w = 1; w < BIT_CLKS/2 - 4; w += 3) begin
      r0 = nrdy_a; e0 = nerr_a;
      hold_a(1'b0, w);
      hold_a(1'b1, 2 * BIT_CLKS);
      chk(nrdy_a == r0 && nerr_a == e0, "R3 glitch no strobe", nrdy_a + nerr_a - r0 - e0, 0);
      chk(data_a == keep, "R7 data kept after glitch", data_a, keep);
    end
    r0 = nrdy_a;
    frame_a(8'h81, 1'b1);
    chk(nrdy_a == r0 + 1 && data_a == 8'h81, "R2 receive after glitches", data_a, 8'h81);

    // R1: long break gives one errored zero word, then nothing while low
    r0 = nrdy_a; e0 = nerr_a;
    hold_a(1'b0, 30 * BIT_CLKS);
    chk(nerr_a == e0 + 1, "R1 break single err", nerr_a - e0, 1);
    chk(nrdy_a == r0, "R1 break no ready", nrdy_a - r0, 0);
    chk(data_a == 8'h00, "R6 break data", data_a, 0);
    hold_a(1'b1, 2 * BIT_CLKS);
    chk(nerr_a == e0 + 1 && nrdy_a == r0, "R1 rise no strobe", nerr_a - e0, 1);
    r0 = nrdy_a;
    frame_a(8'h7E, 1'b1);
    chk(nrdy_a == r0 + 1 && data_a == 8'h7E, "R1 receive after break", data_a, 8'h7E);

    // R8: even parity, good and flipped
    for (int v = 0; v < 256; v += 4) begin
      logic p;
      p = ^8'(v);
      r0 = nrdy_b; e0 = nerr_b;
      frame_b(8'(v), p);
      chk(nrdy_b == r0 + 1 && nerr_b == e0, "R8 good parity ready", nrdy_b - r0, 1);
      chk(data_b == 8'(v), "R8 good parity data", data_b, v);
      r0 = nrdy_b; e0 = nerr_b;
      frame_b(8'(v ^ 8'hFF), ~p);
      chk(nerr_b == e0 + 1 && nrdy_b == r0, "R8 bad parity err", nerr_b - e0, 1);
      chk(data_b == 8'(v ^ 8'hFF), "R8 bad parity data", data_b, v ^ 8'hFF);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule